// File: doc/BRIEF.md
# Register-Array Synchronous SRAM with Lane Writes

This block is a small synchronous static memory built from flip-flops. It holds words of four byte lanes and has a parametrised depth. Every command input is captured on the rising clock edge: the address, the write data, the three chip enables and the write controls. The address comes from a burst address generator outside the block, so each cycle presents one complete access. A write stores either the lanes picked by a lane-select mask or, under the global write control, the whole word. A selected cycle that stores nothing is a read.

A mode input sets the read latency. In flow-through mode, read data comes straight from the array behind the captured address and appears in the cycle after the command. In pipelined mode it passes through one more output register and appears a cycle later. A deselect shuts the output-valid flag in the cycle right after the deselect is captured, which is one stage earlier than read data travels. A pipelined read whose data would arrive in that cycle is therefore suppressed. An active-low output enable masks the output at once, with no clock involved. A sleep input freezes all access and keeps the stored words. Data in and data out are separate buses, and an output-valid flag stands in for a bidirectional pad.

Top module: `sync_sram_bw`

## Requirements
- R1: While reset is asserted, and after it is released with no read issued yet, `rvalid` is 0 and `rdata` is 0. Reset acts asynchronously on the output path.
- R2: With `pipe_mode` = 0, a read captured at edge k drives `rvalid` = 1 with the addressed word on `rdata` after edge k. For a burst this gives a 2-1-1-1 pattern, counting the cycle the command is presented as the first.
- R3: With `pipe_mode` = 1, a read captured at edge k shows its word after edge k+1, provided the command at edge k+1 is selected. Back-to-back reads give one word per cycle, which makes a 3-1-1-1 pattern.
- R4: When `wr_lane_en` = 1 and `lane_sel` is nonzero, only lane i with `lane_sel[i]` = 1 is written. Lane i is bits 8i+7..8i. The other lanes keep their old bytes.
- R5: When `wr_all` = 1, all four lanes are written, whatever `wr_lane_en` and `lane_sel` hold.
- R6: The block is selected only when `cs1_n` = 0, `cs2` = 1 and `cs3_n` = 0. Any other combination is a deselect, and it neither writes nor reads.
- R7: After an edge that captures a deselect or a sleep, `rvalid` is 0 in the following cycle in both modes. This holds even for a pipelined read captured one edge earlier.
- R8: `oe_n` = 1 forces `rvalid` to 0 and `rdata` to 0 in the same cycle, combinationally. Setting `oe_n` back to 0 restores the pending output with no clock edge.
- R9: While `sleep` = 1, writes and reads are ignored, `rvalid` is 0 and the stored words are kept. A command at the first edge with `sleep` = 0 is served normally.
- R10: A read of an address in the cycle after a write to that address returns the newly written word.
- R11: `wr_lane_en` = 1 with `lane_sel` = 0 and `wr_all` = 0 is a read, and it changes no stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control and output registers |
| pipe_mode | input | 1 | 1 = pipelined reads, 0 = flow-through reads |
| cs1_n | input | 1 | Chip enable, active low |
| cs2 | input | 1 | Chip enable, active high |
| cs3_n | input | 1 | Chip enable, active low |
| addr | input | AW | Word address from the external burst generator |
| wdata | input | LANES*LANE_W | Write data |
| wr_all | input | 1 | Global write of all lanes |
| wr_lane_en | input | 1 | Lane write enable, qualified by `lane_sel` |
| lane_sel | input | LANES | Per-lane write select |
| oe_n | input | 1 | Output enable, active low, combinational |
| sleep | input | 1 | Suspends all access, contents kept |
| rdata | output | LANES*LANE_W | Read data, zero when `rvalid` is 0 |
| rvalid | output | 1 | Read data valid (pad driven) |

## Verification
Reads are tried back to back, interleaved with writes and separated by deselects, in both latency modes. These runs separate the one-cycle flow-through path from the two-cycle pipelined path, and show whether a deselect cuts pipelined data one stage early. Writes use a full-word pattern, a sparse lane mask, a global write with every lane select low, and a lane enable with no lanes. Each write is read back, and the readback shows which bytes moved. Sleep is entered and left in both modes, and output enable is toggled in mid-cycle.

// File: rtl/sync_sram_bw.sv
`timescale 1ns/100ps
module sync_sram_bw #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  parameter int DEPTH  = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int DW = LANES * LANE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pipe_mode,
  input  logic          cs1_n,
  input  logic          cs2,
  input  logic          cs3_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          wr_all,
  input  logic          wr_lane_en,
  input  logic [LANES-1:0] lane_sel,
  input  logic          oe_n,
  input  logic          sleep,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] addr_q;
  logic [DW-1:0] dout_q;
  logic          rd_q, sel_q, vld_q;

  wire sel     = !cs1_n && cs2 && !cs3_n && !sleep;
  wire lane_wr = wr_lane_en && (|lane_sel);
  wire wr      = sel && (wr_all || lane_wr);
  wire rd      = sel && !wr;

  always_ff @(posedge clk) begin
    if (wr) begin
      for (int i = 0; i < LANES; i++) begin
        if (wr_all || lane_sel[i])
          mem[addr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      sel_q  <= 1'b0;
      vld_q  <= 1'b0;
      addr_q <= '0;
      dout_q <= '0;
    end else begin
      rd_q   <= rd;
      sel_q  <= sel;
      addr_q <= addr;
      vld_q  <= rd_q;
      dout_q <= mem[addr_q];
    end
  end

  wire live = pipe_mode ? (vld_q && sel_q) : rd_q;
  assign rvalid = rst_n && !oe_n && !sleep && live;
  assign rdata  = rvalid ? (pipe_mode ? dout_q : mem[addr_q]) : '0;

  a_r2_flow_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && rd) |=> (rvalid || oe_n || sleep || pipe_mode));

  a_r3_pipe_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && rd) ##1 (pipe_mode && sel) |=> (rvalid || oe_n || sleep || !pipe_mode));

  a_r7_deselect_off: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !rvalid);

  a_r9_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !rvalid);

  a_r10_write_then_read: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_all && sel && !pipe_mode) ##1 (rd && !pipe_mode && addr == $past(addr))
      |=> (oe_n || sleep || pipe_mode || rdata == $past(wdata, 2)));

endmodule

// File: tb/tb_sync_sram_bw.sv
`timescale 1ns/100ps
module tb_sync_sram_bw;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pipe_mode = 1'b0, cs1_n = 1'b1, cs2 = 1'b0, cs3_n = 1'b1;
  logic [5:0] addr = '0;
  logic [31:0] wdata = '0;
  logic wr_all = 1'b0, wr_lane_en = 1'b0, oe_n = 1'b0, sleep = 1'b0;
  logic [3:0] lane_sel = '0;
  logic [31:0] rdata;
  logic rvalid;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  sync_sram_bw dut (.clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .cs1_n(cs1_n),
    .cs2(cs2), .cs3_n(cs3_n), .addr(addr), .wdata(wdata), .wr_all(wr_all),
    .wr_lane_en(wr_lane_en), .lane_sel(lane_sel), .oe_n(oe_n), .sleep(sleep),
    .rdata(rdata), .rvalid(rvalid));

  typedef struct packed {
    logic [3:0] req; logic pm; logic [2:0] cs; logic ga; logic lw; logic [3:0] ls;
    logic oe; logic slp; logic [5:0] a; logic [31:0] d; logic ev; logic [31:0] ed;
  } vec_t;

  localparam int N = 27;
  localparam vec_t TBL [N] = '{
    {4'd5, 1'b0,3'b010,1'b1,1'b0,4'b0000,1'b0,1'b0,6'd1,32'hAABBCCDD,1'b0,32'h0},        // R5 full write
    {4'd10,1'b0,3'b010,1'b0,1'b0,4'b0000,1'b0,1'b0,6'd1,32'h0,1'b1,32'hAABBCCDD},        // R10 R2
    {4'd4, 1'b0,3'b010,1'b0,1'b1,4'b0101,1'b0,1'b0,6'd1,32'h11223344,1'b0,32'h0},        // R4
    {4'd4, 1'b0,3'b010,1'b0,1'b0,4'b0000,1'b0,1'b0,6'd1,32'h0,1'b1,32'hAA22CC44},        // R4
    {4'd5, 1'b0,3'b010,1'b1,1'b0,4'b0000,1'b0,1'b0,6'd2,32'h55667788,1'b0,32'h0},        // R5
    {4'd5, 1'b0,3'b010,1'b0,1'b0,4'b0000,1'b0,1'b0,6'd2,32'h0,1'b1,32'h55667788},        // R5
    {4'd11,1'b0,3'b010,1'b0,1'b1,4'b0000,1'b0,1'b0,6'd2,32'hFFFFFFFF,1'b1,32'h55667788}, // R11
    {4'd6, 1'b0,3'b110,1'b1,1'b0,4'b0000,1'b0,1'b0,6'd2,32'h0,1'b0,32'h0},               // R6
    {4'd6, 1'b0,3'b010,1'b0,1'b0,4'b0000,1'b0,1'b0,6'd2,32'h0,1'b1,32'h55667788},        // R6
    {4'd8, 1'b0,3'b010,1'b0,1'b0,4'b0000,1'b1,1'b0,6'd1,32'h0,1'b0,32'h0},               // R8
    {4'd9, 1'b0,3'b010,1'b1,1'b0,4'b0000,1'b0,1'b1,6'd1,32'h0,1'b0,32'h0},               // R9
    {4'd9, 1'b0,3'b010,1'b0,1'b0,4'b0000,1'b0,1'b0,6'd1,32'h0,1'b1,32'hAA22CC44},        // R9
    {4'd7, 1'b1,3'b000,1'b0,1'b0,4'b0000,1'b0,1'b0,6'd0,32'h0,1'b0,32'h0},               // R7
    {4'd3, 1'b1,3'b010,1'b0,1'b0,4'b0000,1'b0,1'b0,6'd1,32'h0,1'b0,32'h0},               // R3
    {4'd3, 1'b1,3'b010,1'b0,1'b0,4'b0000,1'b0,1'b0,6'd2,32'h0,1'b1,32'hAA22CC44},        // R3
    {4'd3, 1'b1,3'b010,1'b0,1'b0,4'b0000,1'b0,1'b0,6'd1,32'h0,1'b1,32'h55667788},        // R3
    {4'd7, 1'b1,3'b000,1'b0,1'b0,4'b0000,1'b0,1'b0,6'd0,32'h0,1'b0,32'h0},               // R7
    {4'd3, 1'b1,3'b010,1'b0,1'b0,4'b0000,1'b0,1'b0,6'd2,32'h0,1'b0,32'h0},               // R3
    {4'd7, 1'b1,3'b010,1'b1,1'b0,4'b0000,1'b0,1'b0,6'd3,32'h0BADF00D,1'b1,32'h55667788}, // R7
    {4'd3, 1'b1,3'b010,1'b0,1'b0,4'b0000,1'b0,1'b0,6'd3,32'h0,1'b0,32'h0},               // R3
    {4'd7, 1'b1,3'b011,1'b0,1'b0,4'b0000,1'b0,1'b0,6'd0,32'h0,1'b0,32'h0},               // R7
    {4'd3, 1'b1,3'b010,1'b0,1'b0,4'b0000,1'b0,1'b0,6'd3,32'h0,1'b0,32'h0},               // R3
    {4'd10,1'b1,3'b010,1'b0,1'b0,4'b0000,1'b0,1'b0,6'd3,32'h0,1'b1,32'h0BADF00D},        // R10
    {4'd4, 1'b1,3'b010,1'b0,1'b1,4'b1000,1'b0,1'b0,6'd3,32'hEE000000,1'b1,32'h0BADF00D}, // R4
    {4'd4, 1'b1,3'b010,1'b0,1'b0,4'b0000,1'b0,1'b0,6'd3,32'h0,1'b0,32'h0},               // R4
    {4'd4, 1'b1,3'b010,1'b0,1'b0,4'b0000,1'b0,1'b0,6'd3,32'h0,1'b1,32'hEEADF00D},        // R4
    {4'd7, 1'b1,3'b100,1'b0,1'b0,4'b0000,1'b0,1'b0,6'd0,32'h0,1'b0,32'h0}                // R7
  };

  task automatic chk(input int req, input logic ev, input logic [31:0] ed);
    n_run++;
    if (rvalid !== ev || rdata !== ed) begin
      n_fail++;
      $display("FAIL R%0d: got rvalid=%0b rdata=%h, expected rvalid=%0b rdata=%h",
               req, rvalid, rdata, ev, ed);
    end
  endtask

  task automatic apply(input vec_t v);
    pipe_mode = v.pm; {cs1_n, cs2, cs3_n} = v.cs; wr_all = v.ga; wr_lane_en = v.lw;
    lane_sel = v.ls; oe_n = v.oe; sleep = v.slp; addr = v.a; wdata = v.d;
  endtask

  task automatic cmd(input logic pm, input logic [2:0] cs, input logic ga, input logic slp,
                     input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    pipe_mode = pm; {cs1_n, cs2, cs3_n} = cs; wr_all = ga; wr_lane_en = 1'b0;
    lane_sel = '0; oe_n = 1'b0; sleep = slp; addr = a; wdata = d;
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #80000;
    n_run++; n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    #1;
    chk(1, 1'b0, 32'h0);                     // R1 during reset
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk(1, 1'b0, 32'h0);                     // R1 after release
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      apply(TBL[i]);
      @(posedge clk); #1;
      chk(int'(TBL[i].req), TBL[i].ev, TBL[i].ed);
    end
    // R8: output enable toggled mid-cycle in pipelined mode
    cmd(1'b1, 3'b010, 1'b0, 1'b0, 6'd3, 32'h0);
    cmd(1'b1, 3'b010, 1'b0, 1'b0, 6'd3, 32'h0);
    chk(8, 1'b1, 32'hEEADF00D);
    oe_n = 1'b1; #0.4;
    chk(8, 1'b0, 32'h0);
    oe_n = 1'b0; #0.3;
    chk(8, 1'b1, 32'hEEADF00D);
    // R9: pipelined sleep with write attempts, contents kept
    cmd(1'b1, 3'b010, 1'b1, 1'b1, 6'd3, 32'h12345678);
    chk(9, 1'b0, 32'h0);
    cmd(1'b1, 3'b010, 1'b1, 1'b1, 6'd3, 32'h12345678);
    chk(9, 1'b0, 32'h0);
    cmd(1'b1, 3'b010, 1'b0, 1'b0, 6'd3, 32'h0);
    cmd(1'b1, 3'b010, 1'b0, 1'b0, 6'd3, 32'h0);
    chk(9, 1'b1, 32'hEEADF00D);
    // R1: reset asserted while output is valid
    rst_n = 1'b0; #0.4;
    chk(1, 1'b0, 32'h0);
    finish_run();
  end
endmodule